// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer

This block is an up-counting timer that sits on a simple synchronous register bus. An input-clock divider sets the pace of the counter: the counter takes one step after every PSC+1 clock cycles while counting is switched on. When the next step would bring the counter to the programmed reload limit, the counter goes back to zero instead. This is an update event. If the update interrupt is enabled, the event also raises a status flag and sends a one-cycle pulse on the interrupt line.

Software sets the divider, the limit and the counter value through the bus. It can force the counter back to zero with an event-generation write and clears the status flag by writing zeros into it. A zero limit turns update events off, and the counter then runs free. A set of extra locations only stores whatever software writes there, so that drivers can program them without side effects. All registers are 32 bits wide. The counter, divider and limit registers hold CNT_W bits, and the bits above them read as zero.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset every register reads zero and `irqOut` is low.
- R2: While bit 0 of the control word (offset 0x00) is 1, the counter (offset 0x24) advances by one every PSC+1 clock cycles, where PSC is the divider value at offset 0x28.
- R3: With a nonzero limit ARR (offset 0x2C), a step that would make the counter equal to ARR loads zero instead and produces an update event. The counter therefore cycles through 0 to ARR-1.
- R4: An update event sets status bit 0 (offset 0x10) and drives `irqOut` high for one cycle, on the clock edge where the counter returns to zero. This happens only when interrupt-enable bit 0 (offset 0x0C) is 1. When that bit is 0, neither the flag nor the line changes.
- R5: A write to the status word ANDs the written bit 0 into the flag: 0 clears it and 1 keeps it. An update event in the same cycle as the write leaves the flag set.
- R6: A write to the event word (offset 0x14) with bit 0 set zeroes the counter and restarts the divider phase, with no interrupt. The event word reads back the value last written to it.
- R7: With ARR equal to zero, no update event occurs. The counter counts freely and wraps from 2^CNT_W-1 to 0.
- R8: A write to the divider register changes the rate, keeps the counter value and restarts the divider phase.
- R9: A write to the counter register loads the written value and restarts the divider phase. Counting continues from the loaded value.
- R10: While control bit 0 is 0, the counter and the divider phase hold their values.
- R11: Offsets 0x04, 0x08, 0x18, 0x1C, 0x20, 0x34, 0x38, 0x3C, 0x40, 0x48, 0x4C and 0x50 read back the full 32-bit value last written to them and have no effect on counting.
- R12: Any other offset reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset; the two low bits are ignored |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the current state and address; zero when not selected |
| irqOut | output | 1 | One-cycle update interrupt pulse |

## Verification
A wrong divider phase or a wrong counter value does not stay hidden. Within at most PSC+1 cycles it shows up as a counter read that is off by one step. Within one reload period it shows up as an interrupt pulse one or more cycles away from where it should be. A stuck or lost status flag is seen on the next status read, and a wrongly decoded offset is seen on the first read-back of that location. The reference model is compared on every clock for both the interrupt line and any read in flight, so the first cycle of divergence is the one reported.

// File: rtl/prt_pkg.sv
package prt_pkg;

  localparam int DATA_W = 32;

  // Word indices (byte offset / 4) of the functional registers
  localparam int W_CTRL  = 0;
  localparam int W_INTEN = 3;
  localparam int W_STAT  = 4;
  localparam int W_EVT   = 5;
  localparam int W_CNT   = 9;
  localparam int W_PSC   = 10;
  localparam int W_ARR   = 11;

  // Storage-only locations
  localparam int SPARE_N = 12;

  function automatic int spareSlot(input int word);
    case (word)
      1:       return 0;
      2:       return 1;
      6:       return 2;
      7:       return 3;
      8:       return 4;
      13:      return 5;
      14:      return 6;
      15:      return 7;
      16:      return 8;
      18:      return 9;
      19:      return 10;
      20:      return 11;
      default: return -1;
    endcase
  endfunction

  // Strobes from the register control to the counting datapath
  typedef struct packed {
    logic countEn;
    logic loadCnt;
    logic loadPsc;
    logic loadArr;
    logic zeroCnt;
  } dpCmd_t;

endpackage

// File: rtl/prt_datapath.sv
module prt_datapath
  import prt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [CNT_W-1:0] loadData,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] pscVal,
  output logic [CNT_W-1:0] arrVal,
  output logic             updEvt
);

  logic [CNT_W-1:0] preCnt;
  logic [CNT_W-1:0] cntInc;
  logic             tick;
  logic             phaseRestart;

  assign tick         = cmd.countEn && (preCnt == pscVal);
  assign cntInc       = cntVal + CNT_W'(1);
  assign updEvt       = tick && (arrVal != '0) && (cntInc == arrVal);
  assign phaseRestart = cmd.loadPsc || cmd.loadCnt || cmd.zeroCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscVal <= '0;
      arrVal <= '0;
    end else begin
      if (cmd.loadPsc) pscVal <= loadData;
      if (cmd.loadArr) arrVal <= loadData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (phaseRestart) begin
      preCnt <= '0;
    end else if (cmd.countEn) begin
      preCnt <= tick ? '0 : preCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (cmd.zeroCnt) begin
      cntVal <= '0;
    end else if (cmd.loadCnt) begin
      cntVal <= loadData;
    end else if (tick) begin
      cntVal <= updEvt ? '0 : cntInc;
    end
  end

endmodule

// File: rtl/prt_ctrl.sv
module prt_ctrl
  import prt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  input  logic              updEvt,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  pscVal,
  input  logic [CNT_W-1:0]  arrVal,
  output dpCmd_t            cmd,
  output logic              statusFlag
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic [1:0]        unusedAddrLsb;
  logic              wrEn;
  int                slotIdx;

  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] intEnReg;
  logic [DATA_W-1:0] evtReg;
  logic [DATA_W-1:0] spareReg [SPARE_N];

  assign wordIdx       = busAddr[ADDR_W-1:2];
  assign unusedAddrLsb = busAddr[1:0];
  assign wrEn          = busSel && busWrite;

  always_comb slotIdx = spareSlot(int'(wordIdx));

  function automatic logic hit(input logic [WORD_W-1:0] w, input int target);
    return w == WORD_W'(target);
  endfunction

  // Strobes to the datapath
  always_comb begin
    cmd.countEn = ctrlReg[0];
    cmd.loadCnt = wrEn && hit(wordIdx, W_CNT);
    cmd.loadPsc = wrEn && hit(wordIdx, W_PSC);
    cmd.loadArr = wrEn && hit(wordIdx, W_ARR);
    cmd.zeroCnt = wrEn && hit(wordIdx, W_EVT) && busWdata[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      intEnReg <= '0;
      evtReg   <= '0;
    end else if (wrEn) begin
      if (hit(wordIdx, W_CTRL))  ctrlReg  <= busWdata;
      if (hit(wordIdx, W_INTEN)) intEnReg <= busWdata;
      if (hit(wordIdx, W_EVT))   evtReg   <= busWdata;
    end
  end

  // Status flag: software ANDs, hardware set wins
  logic statusNext;
  logic raise;

  assign raise = updEvt && intEnReg[0] && ctrlReg[0];

  always_comb begin
    statusNext = statusFlag;
    if (wrEn && hit(wordIdx, W_STAT)) statusNext = statusFlag & busWdata[0];
    if (raise) statusNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusFlag <= 1'b0;
      irqOut     <= 1'b0;
    end else begin
      statusFlag <= statusNext;
      irqOut     <= raise;
    end
  end

  // Storage-only locations
  for (genvar g = 0; g < SPARE_N; g++) begin : g_spare
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        spareReg[g] <= '0;
      end else if (wrEn && slotIdx == g) begin
        spareReg[g] <= busWdata;
      end
    end
  end

  // Read mux
  always_comb begin
    busRdata = '0;
    if (busSel) begin
      if (hit(wordIdx, W_CTRL))  busRdata = ctrlReg;
      if (hit(wordIdx, W_INTEN)) busRdata = intEnReg;
      if (hit(wordIdx, W_STAT))  busRdata = {{(DATA_W-1){1'b0}}, statusFlag};
      if (hit(wordIdx, W_EVT))   busRdata = evtReg;
      if (hit(wordIdx, W_CNT))   busRdata = DATA_W'(cntVal);
      if (hit(wordIdx, W_PSC))   busRdata = DATA_W'(pscVal);
      if (hit(wordIdx, W_ARR))   busRdata = DATA_W'(arrVal);
      for (int i = 0; i < SPARE_N; i++) begin
        if (slotIdx == i) busRdata = spareReg[i];
      end
    end
  end

endmodule

// File: rtl/prescaled_reload_timer.sv
module prescaled_reload_timer
  import prt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqOut
);

  dpCmd_t           cmd;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] pscVal;
  logic [CNT_W-1:0] arrVal;
  logic             updEvt;
  logic             statusFlag;
  logic             countEn;

  assign countEn = cmd.countEn;

  prt_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busSel     (busSel),
    .busWrite   (busWrite),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .irqOut     (irqOut),
    .updEvt     (updEvt),
    .cntVal     (cntVal),
    .pscVal     (pscVal),
    .arrVal     (arrVal),
    .cmd        (cmd),
    .statusFlag (statusFlag)
  );

  prt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .loadData (busWdata[CNT_W-1:0]),
    .cntVal   (cntVal),
    .pscVal   (pscVal),
    .arrVal   (arrVal),
    .updEvt   (updEvt)
  );

endmodule

// File: rtl/prt_checker.sv
module prt_checker #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              irqOut,
  input logic              updEvt,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CNT_W-1:0]  arrVal,
  input logic              statusFlag,
  input logic              countEn
);

  logic anyWrite;
  logic ugWrite;

  assign anyWrite = busSel && busWrite;
  assign ugWrite  = anyWrite && (busAddr[ADDR_W-1:2] == (ADDR_W-2)'(5)) && busWdata[0];

  // R4: a pulse always comes with the flag
  p_irq_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> statusFlag);

  // R4: a pulse is always caused by an update in the previous cycle
  p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(updEvt));

  // R3: after an update with no bus write the counter is zero
  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (updEvt && !anyWrite) |=> (cntVal == '0));

  // R7: zero limit never produces an update
  p_zero_arr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (arrVal == '0) |-> !updEvt);

  // R6: update-generation write zeroes the counter
  p_ug_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    ugWrite |=> (cntVal == '0));

  // R10: counter holds while disabled and untouched
  p_hold_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!countEn && !anyWrite) |=> $stable(cntVal));

endmodule

bind prescaled_reload_timer prt_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busSel     (busSel),
  .busWrite   (busWrite),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .irqOut     (irqOut),
  .updEvt     (updEvt),
  .cntVal     (cntVal),
  .arrVal     (arrVal),
  .statusFlag (statusFlag),
  .countEn    (countEn)
);

// File: tb/prescaled_reload_timer_tb.sv
module prescaled_reload_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int CNT_W      = 16;
  localparam logic [31:0] MASK = 32'((64'd1 << CNT_W) - 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busSel = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic              irqOut;

  int    vectors = 0;
  int    miscompares = 0;
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  prescaled_reload_timer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  // ---------------- reference model ----------------
  logic [31:0] mCtrl, mInt, mEvt, mCnt, mPre, mPsc, mArr;
  logic        mStat, mIrq;
  logic [31:0] mSpare [int];

  function automatic bit isSpareWord(input int w);
    return w inside {1, 2, 6, 7, 8, 13, 14, 15, 16, 18, 19, 20};
  endfunction

  function automatic logic [31:0] modelRead(input logic [ADDR_W-1:0] a);
    int w;
    w = int'(a >> 2);
    case (w)
      0:  return mCtrl;
      3:  return mInt;
      4:  return {31'd0, mStat};
      5:  return mEvt;
      9:  return mCnt;
      10: return mPsc;
      11: return mArr;
      default: begin
        if (isSpareWord(w) && mSpare.exists(w)) return mSpare[w];
        return 32'd0;
      end
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCtrl = 0; mInt = 0; mEvt = 0; mCnt = 0; mPre = 0; mPsc = 0; mArr = 0;
      mStat = 0; mIrq = 0;
      mSpare.delete();
    end else begin
      bit en, tick, upd, wr;
      int w;
      en   = mCtrl[0];
      tick = en && (mPre == mPsc);
      upd  = tick && (mArr != 0) && (((mCnt + 1) & MASK) == mArr);
      wr   = busSel && busWrite;
      w    = int'(busAddr >> 2);
      if (en) begin
        if (tick) begin
          mPre = 0;
          mCnt = upd ? 0 : ((mCnt + 1) & MASK);
        end else begin
          mPre = mPre + 1;
        end
      end
      if (wr) begin
        case (w)
          0:  mCtrl = busWdata;
          3:  mInt = busWdata;
          4:  mStat = mStat & busWdata[0];
          5:  begin mEvt = busWdata; if (busWdata[0]) begin mCnt = 0; mPre = 0; end end
          9:  begin mCnt = busWdata & MASK; mPre = 0; end
          10: begin mPsc = busWdata & MASK; mPre = 0; end
          11: mArr = busWdata & MASK;
          default: if (isSpareWord(w)) mSpare[w] = busWdata;
        endcase
      end
      mIrq = upd && mInt[0];
      if (mIrq) mStat = 1;
    end
  end

  // ---------------- comparison every clock ----------------
  always @(negedge clk) begin
    if (rstN) begin
      vectors++;
      if (irqOut !== mIrq) begin
        miscompares++;
        $display("FAIL %s irqOut actual=%b expected=%b at %0t", curReq, irqOut, mIrq, $time);
      end
      if (busSel && !busWrite) begin
        logic [31:0] exp;
        exp = modelRead(busAddr);
        vectors++;
        if (busRdata !== exp) begin
          miscompares++;
          $display("FAIL %s read 0x%02h actual=0x%08h expected=0x%08h at %0t",
                   curReq, busAddr, busRdata, exp, $time);
        end
      end
    end
  end

  // ---------------- bus tasks ----------------
  task automatic busWr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
  endtask

  task automatic busRd(input logic [ADDR_W-1:0] a);
    @(posedge clk); #1;
    busSel = 1; busWrite = 0; busAddr = a; busWdata = 32'hDEAD_BEEF;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      busSel = 0; busWrite = 0;
    end
  endtask

  task automatic pollCnt(input int n);
    for (int i = 0; i < n; i++) busRd(8'h24);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog %s actual=running expected=finished", curReq);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    curReq = "R1";
    for (int a = 0; a < 'h58; a += 4) busRd(ADDR_W'(a));

    curReq = "R11";
    for (int a = 0; a < 'h58; a += 4) busWr(ADDR_W'(a) == 8'h00 ? 8'h04 : 8'h08, 32'h0);
    busWr(8'h04, 32'hA5A5_0001); busWr(8'h08, 32'h1234_5678); busWr(8'h18, 32'hFFFF_FFFF);
    busWr(8'h1C, 32'h0000_0007); busWr(8'h20, 32'h8000_0000); busWr(8'h34, 32'h0BAD_F00D);
    busWr(8'h38, 32'h3); busWr(8'h3C, 32'h44); busWr(8'h40, 32'h555);
    busWr(8'h48, 32'h6666); busWr(8'h4C, 32'h77777); busWr(8'h50, 32'h888888);
    for (int a = 0; a < 'h58; a += 4) busRd(ADDR_W'(a));

    curReq = "R12";
    busWr(8'h30, 32'hFFFF_FFFF); busWr(8'h44, 32'h1234); busWr(8'h60, 32'h9); busWr(8'hFC, 32'h1);
    busRd(8'h30); busRd(8'h44); busRd(8'h60); busRd(8'hFC); busRd(8'h24); busRd(8'h00);

    curReq = "R10";
    busWr(8'h24, 32'd5); pollCnt(6);
    busWr(8'h28, 32'd1); pollCnt(4);

    curReq = "R2";
    busWr(8'h2C, 32'd4); busWr(8'h28, 32'd2); busWr(8'h0C, 32'd1); busWr(8'h24, 32'd0);
    busWr(8'h00, 32'd1);
    pollCnt(20);
    curReq = "R3"; pollCnt(20);
    curReq = "R4"; busRd(8'h10); pollCnt(10); busRd(8'h10);

    curReq = "R5";
    busWr(8'h10, 32'd1); busRd(8'h10);
    busWr(8'h10, 32'd0); busRd(8'h10);
    pollCnt(12); busRd(8'h10);

    curReq = "R4";
    busWr(8'h10, 32'd0); busWr(8'h0C, 32'd0); pollCnt(30); busRd(8'h10);
    busWr(8'h0C, 32'd1);

    curReq = "R8";
    busWr(8'h28, 32'd0); busRd(8'h24); pollCnt(10);
    busWr(8'h28, 32'd3); busRd(8'h24); pollCnt(20); busRd(8'h28);

    curReq = "R9";
    busWr(8'h24, 32'd2); pollCnt(12);
    busWr(8'h24, 32'h0001_0003); pollCnt(6);

    curReq = "R6";
    busWr(8'h14, 32'h0000_0101); busRd(8'h14); pollCnt(8);
    busWr(8'h14, 32'h0000_0002); busRd(8'h14); pollCnt(4);

    curReq = "R7";
    busWr(8'h28, 32'd0); busWr(8'h2C, 32'd0); busWr(8'h24, 32'h0000_FFF0);
    pollCnt(30); busRd(8'h10);

    curReq = "R5";
    busWr(8'h2C, 32'd1); idle(3);
    busWr(8'h10, 32'd0); busRd(8'h10); idle(2);

    curReq = "R10";
    busWr(8'h00, 32'd0); pollCnt(8);
    busWr(8'h2C, 32'd5); busWr(8'h28, 32'd1); busWr(8'h00, 32'd1); pollCnt(15);
    busWr(8'h00, 32'd0); pollCnt(5);

    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule